// File: doc/BRIEF.md
# Receive Character Queue with Trigger, Error Tags and Idle Timeout

This block sits between a serial deserializer and the register that software reads for received characters. Each character arrives with three per-character flags (parity error, framing error, break) and is stored with them. In queued mode up to 16 characters wait in arrival order. The character at the head, with its own flags, is always presented on the read side. A summary bit says whether any stored character carries an error.

A control write port selects the mode, flushes the queue and picks one of four fill thresholds. The threshold drives a trigger-reached output. The same port shows a timeout when a few characters sit below the threshold with no traffic for four character periods. A character-time tick input measures those periods. In single-register mode the block keeps only one character, and a new arrival replaces the old one. A read strobe for the line-status register clears the sticky overrun flag.

Top module: `rx_char_fifo`

## Requirements
- R1: After reset the block is empty and in single-register mode with a threshold of 1. data_ready, overrun, fifo_err, trig_hit, timeout and fifo_mode are all 0.
- R2: In queued mode, characters leave in arrival order, each with its own error flags. A read with buf_rd removes the head. data_ready is 1 while at least one character is stored, and the head outputs read as zero while the block is empty.
- R3: A control write sets the mode from bit 0 (1 = queued) and the threshold from bits 7:6. Writing bit 0 with a value different from the current mode flushes all stored characters. Bit 1 set also flushes. Bit 2 has no effect on this block.
- R4: In queued mode trig_hit is 1 while the stored count is at least the threshold. Threshold code 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. In single-register mode trig_hit equals data_ready.
- R5: In queued mode, a character that arrives while 16 are stored, with no read in the same cycle, is discarded and sets overrun. The stored characters are kept. If a read happens in the same cycle, the character is accepted.
- R6: In single-register mode, a character that arrives while one is held, with no read in the same cycle, replaces it and sets overrun. If a read happens in the same cycle, the character is accepted without overrun.
- R7: overrun stays set until a status_rd strobe clears it. A new overrun event in the same cycle as status_rd leaves it set.
- R8: fifo_err is 1 exactly while at least one stored character has any of its three error flags set.
- R9: timeout is 1 when queued mode is on, the count is non-zero and below the threshold, and four char_tick pulses have occurred since the last arrival, read, flush or empty cycle.
- R10: A read while empty changes nothing.
- R11: A flush takes priority over an arrival or read in the same cycle, so the block is empty afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 8 | Control value: bit0 mode, bit1 flush, bits7:6 threshold |
| rx_valid | input | 1 | A received character is offered this cycle |
| rx_char | input | 8 | Received character |
| rx_perr | input | 1 | Parity error flag of the character |
| rx_ferr | input | 1 | Framing error flag of the character |
| rx_brk | input | 1 | Break flag of the character |
| buf_rd | input | 1 | Read strobe of the receive buffer register |
| status_rd | input | 1 | Read strobe of the line-status register |
| char_tick | input | 1 | One pulse per character period |
| buf_data | output | 8 | Head character |
| head_perr | output | 1 | Parity error of the head character |
| head_ferr | output | 1 | Framing error of the head character |
| head_brk | output | 1 | Break flag of the head character |
| data_ready | output | 1 | At least one character stored |
| overrun | output | 1 | Sticky overrun flag |
| fifo_err | output | 1 | Some stored character carries an error |
| trig_hit | output | 1 | Fill threshold reached |
| timeout | output | 1 | Idle timeout with data below threshold |
| fifo_mode | output | 1 | Queued mode active |

## Verification
Assertions check several properties on every cycle. The count never exceeds the depth, and a flush empties the store. Single-register mode never holds more than one character. Overrun rises after every rejected or overwriting arrival. The running error tally agrees with a scan of the stored flags, and a timeout only occurs with data present below the threshold. Other behaviours can only be shown by the bench scenarios, which compare against a queue model on every clock. These are arrival order and per-character flag placement, the exact threshold values, the four-tick timeout distance, and the bit-2 no-effect case. They also include the same-cycle interactions: read with arrival at full, clear with new overrun, and flush with arrival.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   localparam int CHAR_W = 8;

   typedef struct packed {
      logic              brk;
      logic              ferr;
      logic              perr;
      logic [CHAR_W-1:0] data;
   } rx_ent_t;

   // threshold code to character count
   function automatic logic [4:0] trig_of(input logic [1:0] sel);
      case (sel)
         2'b00:   return 5'd1;
         2'b01:   return 5'd4;
         2'b10:   return 5'd8;
         default: return 5'd14;
      endcase
   endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store
   import rxq_pkg::*;
#(
   parameter int DEPTH = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         flush,
   input  logic                         push,
   input  logic                         pop,
   input  logic                         ovw,
   input  rx_ent_t                      din,
   output rx_ent_t                      head,
   output logic [$clog2(DEPTH+1)-1:0]   count,
   output logic [DEPTH-1:0]             slot_err
);
   localparam int PW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH+1);

   if (DEPTH < 16 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("rxq_store: DEPTH must be a power of two of at least 16");
   end

   rx_ent_t         mem [DEPTH];
   logic [PW-1:0]   wr_ptr, rd_ptr;
   logic [CW-1:0]   cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else if (!ovw) begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         cnt <= cnt + CW'(push) - CW'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (!flush) begin
         if (ovw)       mem[rd_ptr] <= din;
         else if (push) mem[wr_ptr] <= din;
      end
   end

   assign count = cnt;
   assign head  = (cnt != '0) ? mem[rd_ptr] : '0;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [PW-1:0] off;
      assign off         = PW'(i) - rd_ptr;
      assign slot_err[i] = ({1'b0, off} < cnt) &&
                           (mem[i].perr || mem[i].ferr || mem[i].brk);
   end

   AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));                                              // R5
   AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (cnt == '0));                                          // R11
   AST_OVW_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
      ovw |-> !(push || pop));                                         // R6
endmodule

// File: rtl/rxq_errsum.sv
module rxq_errsum #(
   parameter int DEPTH       = 16,
   parameter bit USE_COUNTER = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic             pop,
   input  logic             ovw,
   input  logic             din_err,
   input  logic             head_err,
   input  logic             empty,
   input  logic [DEPTH-1:0] slot_err,
   output logic             any_err
);
   localparam int CW = $clog2(DEPTH+1);

   if (USE_COUNTER) begin : g_count
      logic [CW-1:0] ecnt;
      logic          add, sub;
      logic          scan_any;

      assign add = (push || ovw) && din_err;
      assign sub = (pop  || ovw) && head_err;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     ecnt <= '0;
         else if (flush) ecnt <= '0;
         else            ecnt <= ecnt + CW'(add) - CW'(sub);
      end

      assign any_err  = (ecnt != '0);
      assign scan_any = |slot_err;

      AST_TALLY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
         any_err == scan_any);                                         // R8
      AST_ERR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
         empty |-> !any_err);                                          // R8
   end else begin : g_scan
      assign any_err = |slot_err;
   end
endmodule

// File: rtl/rxq_idle.sv
module rxq_idle #(
   parameter int TICKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   output logic expired
);
   localparam int IW = $clog2(TICKS+1);

   if (TICKS < 1) begin : g_bad_ticks
      $error("rxq_idle: TICKS must be at least 1");
   end

   logic [IW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            cnt <= '0;
      else if (clr)                          cnt <= '0;
      else if (tick && cnt != IW'(TICKS))    cnt <= cnt + 1'b1;
   end

   assign expired = (cnt == IW'(TICKS));

   AST_IDLE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= IW'(TICKS));                                              // R9
   AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !expired);                                               // R9
endmodule

// File: rtl/rx_char_fifo.sv
module rx_char_fifo
   import rxq_pkg::*;
#(
   parameter int DEPTH          = 16,
   parameter int IDLE_TICKS     = 4,
   parameter bit ERR_BY_COUNTER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_we,
   input  logic [7:0]        ctl_wdata,
   input  logic              rx_valid,
   input  logic [CHAR_W-1:0] rx_char,
   input  logic              rx_perr,
   input  logic              rx_ferr,
   input  logic              rx_brk,
   input  logic              buf_rd,
   input  logic              status_rd,
   input  logic              char_tick,
   output logic [CHAR_W-1:0] buf_data,
   output logic              head_perr,
   output logic              head_ferr,
   output logic              head_brk,
   output logic              data_ready,
   output logic              overrun,
   output logic              fifo_err,
   output logic              trig_hit,
   output logic              timeout,
   output logic              fifo_mode
);
   localparam int CW = $clog2(DEPTH+1);

   if (DEPTH < 14) begin : g_bad_top
      $error("rx_char_fifo: DEPTH must hold the largest threshold");
   end

   logic          mode_q, ovr_q;
   logic [1:0]    lvl_q;
   logic [CW-1:0] count, level;
   logic          has, full, flush, pop, push, ovw, ovr_ev, expired;
   rx_ent_t       din, head;
   logic [DEPTH-1:0] slot_err;
   logic          unused_ctl;

   assign unused_ctl = ^ctl_wdata[5:2];

   assign din   = '{brk: rx_brk, ferr: rx_ferr, perr: rx_perr, data: rx_char};
   assign has   = (count != '0);
   assign full  = mode_q ? (count == CW'(DEPTH)) : has;
   assign flush = ctl_we && (ctl_wdata[1] || (ctl_wdata[0] != mode_q));
   assign pop   = buf_rd && has && !flush;
   assign push  = rx_valid && !flush && (!full || pop);
   assign ovr_ev = rx_valid && !flush && full && !pop;
   assign ovw   = ovr_ev && !mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
         lvl_q  <= 2'b00;
         ovr_q  <= 1'b0;
      end else begin
         if (ctl_we) begin
            mode_q <= ctl_wdata[0];
            lvl_q  <= ctl_wdata[7:6];
         end
         if (ovr_ev)         ovr_q <= 1'b1;
         else if (status_rd) ovr_q <= 1'b0;
      end
   end

   rxq_store #(.DEPTH(DEPTH)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .push     (push),
      .pop      (pop),
      .ovw      (ovw),
      .din      (din),
      .head     (head),
      .count    (count),
      .slot_err (slot_err)
   );

   rxq_errsum #(.DEPTH(DEPTH), .USE_COUNTER(ERR_BY_COUNTER)) u_errsum (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .push     (push),
      .pop      (pop),
      .ovw      (ovw),
      .din_err  (rx_perr || rx_ferr || rx_brk),
      .head_err (head.perr || head.ferr || head.brk),
      .empty    (!has),
      .slot_err (slot_err),
      .any_err  (fifo_err)
   );

   rxq_idle #(.TICKS(IDLE_TICKS)) u_idle (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (rx_valid || pop || flush || !has),
      .tick    (char_tick),
      .expired (expired)
   );

   assign level      = CW'(trig_of(lvl_q));
   assign buf_data   = head.data;
   assign head_perr  = head.perr;
   assign head_ferr  = head.ferr;
   assign head_brk   = head.brk;
   assign data_ready = has;
   assign overrun    = ovr_q;
   assign fifo_mode  = mode_q;
   assign trig_hit   = mode_q ? (count >= level) : has;
   assign timeout    = mode_q && has && (count < level) && expired;

   AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q && count == CW'(DEPTH) && rx_valid && !buf_rd && !ctl_we)
      |=> (count == CW'(DEPTH)));                                      // R5
   AST_OVR_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_ev |=> overrun);                                             // R7
   AST_HOLD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_q |-> (count <= CW'(1)));                                  // R6
   AST_TMO_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |-> (data_ready && !trig_hit));                          // R9
   AST_EMPTY_RD: assert property (@(posedge clk) disable iff (!rst_n)
      (!data_ready && buf_rd && !rx_valid) |=> !data_ready);           // R10
   AST_MODE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && ctl_wdata[0] != fifo_mode) |=> !data_ready);          // R3
endmodule

// File: tb/rx_char_fifo_bench.sv
module rx_char_fifo_bench;
   localparam int CLK_NS = 10;
   localparam int DEPTH  = 16;
   localparam int IDLE   = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_we = 1'b0;
   logic [7:0] ctl_wdata = '0;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_char = '0;
   logic       rx_perr = 1'b0, rx_ferr = 1'b0, rx_brk = 1'b0;
   logic       buf_rd = 1'b0, status_rd = 1'b0, char_tick = 1'b0;
   logic [7:0] buf_data;
   logic       head_perr, head_ferr, head_brk;
   logic       data_ready, overrun, fifo_err, trig_hit, timeout, fifo_mode;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_NS/2) clk = ~clk;

   rx_char_fifo u_rx_char_fifo (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .rx_valid(rx_valid), .rx_char(rx_char), .rx_perr(rx_perr),
      .rx_ferr(rx_ferr), .rx_brk(rx_brk), .buf_rd(buf_rd),
      .status_rd(status_rd), .char_tick(char_tick), .buf_data(buf_data),
      .head_perr(head_perr), .head_ferr(head_ferr), .head_brk(head_brk),
      .data_ready(data_ready), .overrun(overrun), .fifo_err(fifo_err),
      .trig_hit(trig_hit), .timeout(timeout), .fifo_mode(fifo_mode)
   );

   // reference model: entries packed as {brk, ferr, perr, data}
   logic [10:0] mq[$];
   bit m_en, m_ovr;
   int m_lvl, m_idle;
   int sz;
   bit fl, full, pp, ev;

   function automatic int lvl_of(input logic [1:0] s);
      return (s == 2'b00) ? 1 : (s == 2'b01) ? 4 : (s == 2'b10) ? 8 : 14;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         mq.delete(); m_en = 0; m_ovr = 0; m_lvl = 1; m_idle = 0;
      end else begin
         sz   = mq.size();
         fl   = ctl_we && (ctl_wdata[1] || (ctl_wdata[0] != m_en));
         full = m_en ? (sz == DEPTH) : (sz != 0);
         pp   = buf_rd && (sz > 0) && !fl;
         ev   = rx_valid && !fl && full && !pp;
         if (fl || rx_valid || pp || sz == 0) m_idle = 0;
         else if (char_tick && m_idle < IDLE) m_idle++;
         if (fl) mq.delete();
         else begin
            if (pp) void'(mq.pop_front());
            if (rx_valid) begin
               if (!full || pp) mq.push_back({rx_brk, rx_ferr, rx_perr, rx_char});
               else if (!m_en) begin
                  mq.delete();
                  mq.push_back({rx_brk, rx_ferr, rx_perr, rx_char});
               end
            end
         end
         if (ev) m_ovr = 1;
         else if (status_rd) m_ovr = 0;
         if (ctl_we) begin
            m_en  = ctl_wdata[0];
            m_lvl = lvl_of(ctl_wdata[7:6]);
         end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         automatic logic [10:0] h = (mq.size() > 0) ? mq[0] : 11'd0;
         automatic bit anyerr = 0;
         automatic int n = mq.size();
         foreach (mq[i]) if (mq[i][10:8] != 3'b000) anyerr = 1;
         chk("R2 data_ready", data_ready, n > 0);
         chk("R2 head", {head_brk, head_ferr, head_perr, buf_data}, h);
         chk("R7 overrun", overrun, m_ovr);
         chk("R8 fifo_err", fifo_err, anyerr);
         chk("R4 trig_hit", trig_hit, m_en ? (n >= m_lvl) : (n > 0));
         chk("R9 timeout", timeout, m_en && n > 0 && n < m_lvl && m_idle >= IDLE);
         chk("R3 fifo_mode", fifo_mode, m_en);
      end
   end

   task automatic drive(input bit we, input logic [7:0] wd, input bit v,
                        input logic [7:0] d, input bit p, input bit f,
                        input bit b, input bit rd, input bit srd, input bit tk);
      ctl_we = we; ctl_wdata = wd; rx_valid = v; rx_char = d;
      rx_perr = p; rx_ferr = f; rx_brk = b; buf_rd = rd;
      status_rd = srd; char_tick = tk;
      @(negedge clk);
      ctl_we = 0; rx_valid = 0; rx_perr = 0; rx_ferr = 0; rx_brk = 0;
      buf_rd = 0; status_rd = 0; char_tick = 0;
   endtask

   task automatic ctl(input logic [7:0] v); drive(1, v, 0, 0, 0, 0, 0, 0, 0, 0); endtask
   task automatic push(input logic [7:0] d, input bit p, input bit f, input bit b);
      drive(0, 0, 1, d, p, f, b, 0, 0, 0);
   endtask
   task automatic pop();  drive(0, 0, 0, 0, 0, 0, 0, 1, 0, 0); endtask
   task automatic sread(); drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 0); endtask
   task automatic tick(); drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 1); endtask

   initial begin
      #(CLK_NS * 200000);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1 ready", data_ready, 0);
      chk("R1 overrun", overrun, 0);
      chk("R1 err", fifo_err, 0);
      chk("R1 trig", trig_hit, 0);
      chk("R1 timeout", timeout, 0);
      chk("R1 mode", fifo_mode, 0);

      ctl(8'h41);
      chk("R3 mode on", fifo_mode, 1);
      push(8'h10, 0, 0, 0); push(8'h11, 0, 0, 0); push(8'h12, 0, 0, 0);
      chk("R4 below 4", trig_hit, 0);
      push(8'h13, 0, 0, 0);
      chk("R4 at 4", trig_hit, 1);
      chk("R2 head first", buf_data, 8'h10);
      pop();
      chk("R2 head second", buf_data, 8'h11);
      pop(); pop(); pop();
      chk("R2 drained", data_ready, 0);
      pop();
      chk("R10 empty read", data_ready, 0);
      chk("R10 no overrun", overrun, 0);

      push(8'h20, 1, 0, 0); push(8'h21, 0, 0, 0); push(8'h22, 0, 1, 1);
      chk("R2 head perr", head_perr, 1);
      chk("R8 err set", fifo_err, 1);
      pop();
      chk("R2 clean head", {head_brk, head_ferr, head_perr}, 0);
      chk("R8 err still", fifo_err, 1);
      pop();
      chk("R2 head ferr+brk", {head_brk, head_ferr}, 2'b11);
      pop();
      chk("R8 err cleared", fifo_err, 0);

      for (int i = 0; i < DEPTH; i++) push(8'h40 + 8'(i), 0, 0, 0);
      push(8'h99, 0, 0, 0);
      chk("R5 overrun", overrun, 1);
      chk("R5 head kept", buf_data, 8'h40);
      drive(0, 0, 1, 8'h77, 0, 0, 0, 1, 0, 0);
      chk("R5 read+arrive", buf_data, 8'h41);
      sread();
      chk("R7 cleared", overrun, 0);
      for (int i = 0; i < DEPTH - 1; i++) pop();
      chk("R5 last accepted", buf_data, 8'h77);
      pop();

      ctl(8'hC1);
      push(8'h50, 0, 0, 0); push(8'h51, 0, 0, 0);
      tick(); tick(); tick();
      chk("R9 three ticks", timeout, 0);
      tick();
      chk("R9 four ticks", timeout, 1);
      pop();
      chk("R9 read restarts", timeout, 0);
      ctl(8'hC5);
      chk("R3 bit2 no effect", data_ready, 1);
      chk("R3 bit2 head", buf_data, 8'h51);
      ctl(8'hC3);
      chk("R3 clear flush", data_ready, 0);
      push(8'h60, 0, 0, 0);
      ctl(8'h00);
      chk("R3 mode flush", data_ready, 0);
      chk("R3 mode off", fifo_mode, 0);

      push(8'h70, 0, 0, 0);
      chk("R4 holding trig", trig_hit, 1);
      push(8'h71, 0, 0, 0);
      chk("R6 overwrite", buf_data, 8'h71);
      chk("R6 overrun", overrun, 1);
      drive(0, 0, 1, 8'h72, 0, 0, 0, 0, 1, 0);
      chk("R7 set wins", overrun, 1);
      chk("R6 overwrite again", buf_data, 8'h72);
      sread();
      chk("R7 clear", overrun, 0);
      drive(0, 0, 1, 8'h73, 0, 0, 0, 1, 0, 0);
      chk("R6 read+arrive", buf_data, 8'h73);
      chk("R6 no overrun", overrun, 0);
      drive(1, 8'h01, 1, 8'h80, 0, 0, 0, 0, 0, 0);
      chk("R11 flush wins", data_ready, 0);

      for (int c = 0; c < 3000; c++) begin
         automatic bit we = ($urandom % 150) == 0;
         automatic logic [7:0] wd;
         case ($urandom % 7)
            0: wd = 8'h01; 1: wd = 8'h41; 2: wd = 8'h81; 3: wd = 8'hC1;
            4: wd = 8'h03; 5: wd = 8'h00; default: wd = 8'h05;
         endcase
         drive(we, wd, ($urandom % 3) == 0, 8'($urandom),
               ($urandom % 8) == 0, ($urandom % 9) == 0, ($urandom % 11) == 0,
               ($urandom % 4) == 0, ($urandom % 16) == 0, ($urandom % 3) == 0);
      end

      @(negedge clk);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule